// File: doc/BRIEF.md
# Flash Program/Erase Status Bit Generator

This block sits on the device side of a byte-wide flash array and supplies the status bits that a host polls while an embedded program or erase algorithm runs. When a program or erase command has been accepted, `stat_en` goes high. Data-bus multiplexing outside the block then presents `dq6_tgl`, `dq5_lim` and `dq2_tgl` on data bits 6, 5 and 2 in place of array data. When the operation has finished, `stat_en` drops and the device reads the array again.

The flash cells, the charge pumps and the command decoder are not part of this block. Simple strobes stand in for them. `op_go` marks the rising edge of the final write pulse of a command sequence, and `op_erase` selects erase or program. `eng_done` reports that the algorithm has finished. `susp_req` and `resume_req` carry the suspend and resume commands, `lim_hit` reports a pulse-count overflow, and `rst_cmd` is the reset command. A read cycle is complete when chip enable and output enable were both low in one cycle and either of them is high in the next.

The controller has eight named states:
- ARRAY: array read.
- PROG: programming.
- ERASE: erasing, which includes the sector-erase time-out.
- SUSP: erase suspended.
- SUSP_PROG: program running during an erase suspend.
- PROT_SHORT and PROT_LONG: fixed-length toggle bursts for protected targets.
- FAIL: the time limit was exceeded.

The transitions are:
- ARRAY→PROG/ERASE on an accepted command.
- ARRAY→PROT_SHORT for a program into a protected sector.
- ARRAY→PROT_LONG for an erase whose selected sectors are all protected.
- PROG/ERASE→ARRAY on `eng_done`.
- ERASE→SUSP on `susp_req`, and SUSP→ERASE on `resume_req`.
- SUSP→SUSP_PROG on a program into an unprotected sector, and SUSP_PROG→SUSP on `eng_done`.
- PROG/ERASE/SUSP_PROG→FAIL on `lim_hit`, and FAIL→ARRAY on `rst_cmd`.
- PROT_SHORT/PROT_LONG→ARRAY when the burst timer expires.

Top module: `flash_status_gen`

## Requirements
- R1: `dq6_tgl` inverts once for every completed read, at any address, while the state is PROG, ERASE, SUSP_PROG, PROT_SHORT, PROT_LONG or FAIL. The new value is visible after the clock edge at which the read end is seen.
- R2: A read is complete in the first cycle in which `ce_n` or `oe_n` is high after a cycle in which both were low. A read ended by `ce_n` counts the same as one ended by `oe_n`, and each read counts exactly once.
- R3: `stat_en` is 0 in ARRAY and 1 from the clock edge that accepts `op_go`. In ARRAY, reads change neither toggle bit. After reset all outputs are 0.
- R4: In SUSP, `dq6_tgl` holds its value on reads. A program into an unprotected sector during SUSP enters SUSP_PROG, where `dq6_tgl` toggles again. `eng_done` then returns the controller to SUSP.
- R5: An erase whose selected sectors are all protected holds `stat_en` high for exactly `CLK_HZ/1e6*LONG_US` cycles (5000 at defaults), with `dq6_tgl` toggling, and then returns to ARRAY.
- R6: A program whose address lies in a protected sector holds `stat_en` high for exactly `CLK_HZ/1e6*SHORT_US` cycles (100 at defaults), then returns to ARRAY.
- R7: When only some of the selected sectors are protected, the erase runs. The sector set is captured at acceptance as `ers_sel & ~sec_prot` and excludes the protected sectors.
- R8: `dq2_tgl` inverts on a completed read in ERASE or SUSP whose sector lies in the captured set. In every other case it keeps its last value. The sector is address bits [18:16] at defaults.
- R9: `lim_hit` in PROG, ERASE or SUSP_PROG enters FAIL. `dq5_lim` is 1 only in FAIL and stays 1 until `rst_cmd`. `dq6_tgl` keeps toggling in FAIL.
- R10: `rst_cmd` in FAIL returns the controller to ARRAY. `eng_done` returns PROG or ERASE to ARRAY. `op_go` is ignored except in ARRAY and SUSP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_addr | input | ADDR_W | Read address |
| op_go | input | 1 | Command sequence accepted (final write edge) |
| op_erase | input | 1 | 1 = erase, 0 = program |
| op_addr | input | ADDR_W | Program target address |
| ers_sel | input | NUM_SECT | Sectors selected for erase |
| sec_prot | input | NUM_SECT | Per-sector protect flags |
| eng_done | input | 1 | Embedded algorithm finished |
| susp_req | input | 1 | Erase suspend command |
| resume_req | input | 1 | Erase resume command |
| lim_hit | input | 1 | Pulse-count limit exceeded |
| rst_cmd | input | 1 | Reset command |
| stat_en | output | 1 | Status replaces array data |
| dq6_tgl | output | 1 | Busy toggle bit |
| dq5_lim | output | 1 | Exceeded-limit flag |
| dq2_tgl | output | 1 | Erase-sector toggle bit |

## Verification
A wrong controller state shows at the ports on the next completed read. A stale busy state leaves `dq6_tgl` flipping where it should hold, or holding where it should flip. A bad captured sector set makes `dq2_tgl` move on an address outside the set, or stay still on one inside it. Timer faults appear as a burst length that is off by at least one cycle. That is seen at the falling edge of `stat_en`, 100 or 5000 cycles after the command.

// File: rtl/fs_pkg.sv
package fs_pkg;
    typedef enum logic [2:0] {
        ST_ARRAY,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_SUSP_PROG,
        ST_PROT_SHORT,
        ST_PROT_LONG,
        ST_FAIL
    } fs_state_e;
endpackage

// File: rtl/fs_read_detect.sv
module fs_read_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic rd_done
);
    logic rd_act;
    logic rd_act_q;

    assign rd_act  = ~ce_n & ~oe_n;
    assign rd_done = rd_act_q & ~rd_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_act_q <= 1'b0;
        else        rd_act_q <= rd_act;
    end
endmodule

// File: rtl/fs_burst_timer.sv
module fs_burst_timer #(
    parameter int SHORT_CYC = 100,
    parameter int LONG_CYC  = 5000,
    localparam int CNT_W    = $clog2(LONG_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_short,
    input  logic             load_long,
    output logic             expired,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load_long)   cnt <= CNT_W'(LONG_CYC - 1);
        else if (load_short)  cnt <= CNT_W'(SHORT_CYC - 1);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/fs_toggle_bits.sv
module fs_toggle_bits #(
    parameter int NUM_SECT = 8,
    localparam int SECT_W  = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_done,
    input  logic [SECT_W-1:0]   rd_sect,
    input  logic                tb6_en,
    input  logic                tb2_en,
    input  logic [NUM_SECT-1:0] sect_mask,
    output logic                tb6,
    output logic                tb2
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb6 <= 1'b0;
            tb2 <= 1'b0;
        end else begin
            if (rd_done && tb6_en)                     tb6 <= ~tb6;
            if (rd_done && tb2_en && sect_mask[rd_sect]) tb2 <= ~tb2;
        end
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fs_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int SHORT_US = 2,
    parameter int LONG_US  = 100,
    parameter int ADDR_W   = 19,
    parameter int NUM_SECT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                oe_n,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                op_go,
    input  logic                op_erase,
    input  logic [ADDR_W-1:0]   op_addr,
    input  logic [NUM_SECT-1:0] ers_sel,
    input  logic [NUM_SECT-1:0] sec_prot,
    input  logic                eng_done,
    input  logic                susp_req,
    input  logic                resume_req,
    input  logic                lim_hit,
    input  logic                rst_cmd,
    output logic                stat_en,
    output logic                dq6_tgl,
    output logic                dq5_lim,
    output logic                dq2_tgl
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int SHORT_CYC  = CYC_PER_US * SHORT_US;
    localparam int LONG_CYC   = CYC_PER_US * LONG_US;
    localparam int SECT_W     = $clog2(NUM_SECT);
    localparam int CNT_W      = $clog2(LONG_CYC + 1);

    fs_state_e st, st_nx;

    logic                rd_done;
    logic [SECT_W-1:0]   rd_sect;
    logic [SECT_W-1:0]   op_sect;
    logic [NUM_SECT-1:0] sect_mask;
    logic [NUM_SECT-1:0] live_sel;
    logic                prog_blocked;
    logic                erase_blocked;
    logic                load_short;
    logic                load_long;
    logic                tmr_exp;
    logic [CNT_W-1:0]    tmr_cnt;
    logic                tb6_en;
    logic                tb2_en;

    assign rd_sect       = rd_addr[ADDR_W-1 -: SECT_W];
    assign op_sect       = op_addr[ADDR_W-1 -: SECT_W];
    assign live_sel      = ers_sel & ~sec_prot;
    assign prog_blocked  = sec_prot[op_sect];
    assign erase_blocked = (live_sel == '0);

    fs_read_detect u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .rd_done (rd_done)
    );

    fs_burst_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_short (load_short),
        .load_long  (load_long),
        .expired    (tmr_exp),
        .cnt        (tmr_cnt)
    );

    fs_toggle_bits #(
        .NUM_SECT (NUM_SECT)
    ) u_tgl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_done   (rd_done),
        .rd_sect   (rd_sect),
        .tb6_en    (tb6_en),
        .tb2_en    (tb2_en),
        .sect_mask (sect_mask),
        .tb6       (dq6_tgl),
        .tb2       (dq2_tgl)
    );

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_ARRAY: begin
                if (op_go) begin
                    if (op_erase) st_nx = erase_blocked ? ST_PROT_LONG  : ST_ERASE;
                    else          st_nx = prog_blocked  ? ST_PROT_SHORT : ST_PROG;
                end
            end
            ST_PROG: begin
                if (lim_hit)       st_nx = ST_FAIL;
                else if (eng_done) st_nx = ST_ARRAY;
            end
            ST_ERASE: begin
                if (lim_hit)       st_nx = ST_FAIL;
                else if (susp_req) st_nx = ST_SUSP;
                else if (eng_done) st_nx = ST_ARRAY;
            end
            ST_SUSP: begin
                if (resume_req)                             st_nx = ST_ERASE;
                else if (op_go && !op_erase && !prog_blocked) st_nx = ST_SUSP_PROG;
            end
            ST_SUSP_PROG: begin
                if (lim_hit)       st_nx = ST_FAIL;
                else if (eng_done) st_nx = ST_SUSP;
            end
            ST_PROT_SHORT,
            ST_PROT_LONG: begin
                if (tmr_exp) st_nx = ST_ARRAY;
            end
            ST_FAIL: begin
                if (rst_cmd) st_nx = ST_ARRAY;
            end
            default: st_nx = ST_ARRAY;
        endcase
    end

    // State register and captured erase set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_ARRAY;
            sect_mask <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_ARRAY && op_go && op_erase) sect_mask <= live_sel;
        end
    end

    // Output and control decode
    always_comb begin
        stat_en    = 1'b1;
        dq5_lim    = 1'b0;
        tb6_en     = 1'b0;
        tb2_en     = 1'b0;
        load_short = 1'b0;
        load_long  = 1'b0;
        unique case (st)
            ST_ARRAY: begin
                stat_en    = 1'b0;
                load_short = op_go && !op_erase && prog_blocked;
                load_long  = op_go && op_erase && erase_blocked;
            end
            ST_PROG:       tb6_en = 1'b1;
            ST_ERASE: begin
                tb6_en = 1'b1;
                tb2_en = 1'b1;
            end
            ST_SUSP:       tb2_en = 1'b1;
            ST_SUSP_PROG:  tb6_en = 1'b1;
            ST_PROT_SHORT: tb6_en = 1'b1;
            ST_PROT_LONG:  tb6_en = 1'b1;
            ST_FAIL: begin
                tb6_en  = 1'b1;
                dq5_lim = 1'b1;
            end
            default: stat_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/fs_status_checker.sv
module fs_status_checker
    import fs_pkg::*;
#(
    parameter int NUM_SECT  = 8,
    parameter int SHORT_CYC = 100,
    parameter int LONG_CYC  = 5000,
    parameter int CNT_W     = 13,
    localparam int SECT_W   = $clog2(NUM_SECT)
) (
    input logic                clk,
    input logic                rst_n,
    input fs_state_e           st,
    input logic                rd_done,
    input logic [SECT_W-1:0]   rd_sect,
    input logic [NUM_SECT-1:0] sect_mask,
    input logic [CNT_W-1:0]    tmr_cnt,
    input logic                rst_cmd,
    input logic                dq6_tgl,
    input logic                dq2_tgl,
    input logic                dq5_lim
);
    a_r3_array_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARRAY) |=> ($stable(dq6_tgl) && $stable(dq2_tgl)));

    a_r4_susp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP) |=> $stable(dq6_tgl));

    a_r1_busy_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && st inside {ST_PROG, ST_ERASE, ST_SUSP_PROG, ST_PROT_SHORT, ST_PROT_LONG, ST_FAIL})
        |=> (dq6_tgl != $past(dq6_tgl)));

    a_r8_tb2_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !sect_mask[rd_sect]) |=> $stable(dq2_tgl));

    a_r9_sticky_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (dq5_lim && !rst_cmd) |=> dq5_lim);

    a_r6_short_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROT_SHORT) |-> (int'(tmr_cnt) < SHORT_CYC));

    a_r5_long_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROT_LONG) |-> (int'(tmr_cnt) < LONG_CYC));
endmodule

bind flash_status_gen fs_status_checker #(
    .NUM_SECT  (NUM_SECT),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .rd_done   (rd_done),
    .rd_sect   (rd_sect),
    .sect_mask (sect_mask),
    .tmr_cnt   (tmr_cnt),
    .rst_cmd   (rst_cmd),
    .dq6_tgl   (dq6_tgl),
    .dq2_tgl   (dq2_tgl),
    .dq5_lim   (dq5_lim)
);

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
    localparam int ADDR_W = 19;
    localparam int NS     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] rd_addr = '0, op_addr = '0;
    logic op_go = 0, op_erase = 0, eng_done = 0, susp_req = 0, resume_req = 0;
    logic lim_hit = 0, rst_cmd = 0;
    logic [NS-1:0] ers_sel = '0, sec_prot = '0;
    logic stat_en, dq6_tgl, dq5_lim, dq2_tgl;

    int n_cmp = 0;
    int n_bad = 0;
    logic e6 = 0, e2 = 0;

    always #10 clk = ~clk;

    flash_status_gen i_flash_status_gen (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .rd_addr(rd_addr),
        .op_go(op_go), .op_erase(op_erase), .op_addr(op_addr), .ers_sel(ers_sel),
        .sec_prot(sec_prot), .eng_done(eng_done), .susp_req(susp_req),
        .resume_req(resume_req), .lim_hit(lim_hit), .rst_cmd(rst_cmd),
        .stat_en(stat_en), .dq6_tgl(dq6_tgl), .dq5_lim(dq5_lim), .dq2_tgl(dq2_tgl)
    );

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] sa(int s);
        return {s[2:0], 16'h0123};
    endfunction

    // One read to sector s; ended by ce_n when by_ce is set, else by oe_n.
    task automatic rd(int s, bit by_ce);
        @(negedge clk);
        rd_addr = sa(s);
        ce_n = 0; oe_n = 0;
        @(negedge clk);
        if (by_ce) ce_n = 1; else oe_n = 1;
        @(negedge clk);
        ce_n = 1; oe_n = 1;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1;
        @(negedge clk); sig = 0;
    endtask

    task automatic start(bit ers, int s);
        @(negedge clk);
        op_erase = ers; op_addr = sa(s); op_go = 1;
        @(negedge clk);
        op_go = 0;
    endtask

    task automatic chk_bits(string req);
        check({req, " dq6"}, dq6_tgl, e6);
        check({req, " dq2"}, dq2_tgl, e2);
    endtask

    task automatic t_reset();
        check("R3 reset stat_en", stat_en, 0);
        check("R3 reset dq5", dq5_lim, 0);
        chk_bits("R3 reset");
    endtask

    task automatic t_program();
        start(0, 1);
        check("R3 stat_en after go", stat_en, 1);
        rd(1, 0); e6 = ~e6; chk_bits("R1 oe-ended read");
        rd(6, 1); e6 = ~e6; chk_bits("R2 ce-ended read");
        pulse(eng_done);
        check("R10 done to array", stat_en, 0);
        rd(1, 0); chk_bits("R3 array read frozen");
    endtask

    task automatic t_erase_partial();
        ers_sel = 8'b0000_0110; sec_prot = 8'b0000_0100;
        start(1, 0);
        check("R7 erase runs", stat_en, 1);
        rd(1, 0); e6 = ~e6; e2 = ~e2; chk_bits("R8 selected sector");
        rd(2, 0); e6 = ~e6; chk_bits("R7 protected sector skipped");
        rd(5, 1); e6 = ~e6; chk_bits("R8 unselected sector");
        pulse(susp_req);
        rd(1, 0); e2 = ~e2; chk_bits("R4 suspend tb6 hold / R8 tb2");
        rd(4, 0); chk_bits("R4 suspend outside");
        start(0, 3);
        rd(0, 0); e6 = ~e6; chk_bits("R4 suspend-program");
        rd(1, 0); e6 = ~e6; chk_bits("R4 suspend-program tb2 held");
        pulse(eng_done);
        check("R4 back to suspend", stat_en, 1);
        rd(0, 1); chk_bits("R4 suspend again");
        pulse(resume_req);
        rd(1, 1); e6 = ~e6; e2 = ~e2; chk_bits("R8 resumed");
        pulse(eng_done);
        check("R10 erase done", stat_en, 0);
        ers_sel = '0; sec_prot = '0;
    endtask

    task automatic burst(bit ers, int s, int exp_len, string req);
        int n = 0;
        start(ers, s);
        while (stat_en && n < 10000) begin
            n++;
            @(negedge clk);
        end
        check(req, n, exp_len);
    endtask

    task automatic t_prot_prog();
        sec_prot = 8'b0000_1000;
        start(0, 3);
        rd(2, 0); e6 = ~e6; chk_bits("R6 burst toggles");
        @(negedge clk);
        while (stat_en) @(negedge clk);
        burst(0, 3, 100, "R6 short burst length");
        sec_prot = '0;
    endtask

    task automatic t_prot_erase();
        ers_sel = 8'b0000_1000; sec_prot = 8'b0000_1000;
        burst(1, 0, 5000, "R5 long burst length");
        ers_sel = '0; sec_prot = '0;
    endtask

    task automatic t_fail();
        start(0, 2);
        pulse(lim_hit);
        check("R9 dq5 set", dq5_lim, 1);
        rd(4, 0); e6 = ~e6; chk_bits("R9 fail still toggles");
        repeat (5) @(negedge clk);
        check("R9 dq5 sticky", dq5_lim, 1);
        start(0, 1);
        check("R10 go ignored in fail", dq5_lim, 1);
        pulse(rst_cmd);
        check("R10 reset cmd clears dq5", dq5_lim, 0);
        check("R10 reset cmd to array", stat_en, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase_partial();
        t_prot_prog();
        t_prot_erase();
        t_fail();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule